// File: doc/BRIEF.md
# Synchronous Shift Serial Port

This block is the serial port of a small 8-bit controller, restricted to its synchronous shift-register mode. It drives a shift clock, sends a byte on a data output or takes one in from a data input, and raises a transmit-done or receive-done flag when the byte is complete. One bit takes one machine cycle of `CYC` clock periods. In each bit window the shift clock is low for the first `RISE` periods and high for the rest. Data bits leave and arrive least significant bit first.

Software reaches the port through a one-bit address register bus. Address 0 is the control register. Address 1 is the data register: a write starts a transmission, and a read returns the last received byte. Reception is level-armed. It runs whenever the port is idle, the mode field is zero, the receive-enable bit is set and the receive-done flag is clear. The two flags are also driven out as request lines. Only software clears them.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the control register reads 0x00, the receive buffer reads 0x00, and sclk_o, dat_o, ti_o and ri_o are 1, 1, 0 and 0.
- R2: The control register is at address 0. Its bit 7:6 is mode, bit 5 is multi, bit 4 is rx_en, bit 3 is tx9, bit 2 is rx9, bit 1 is ti and bit 0 is ri. Every bit reads back as written. Address 1 reads the receive buffer.
- R3: A write to address 1 while idle with mode 00 starts a transmission at that clock edge. Each bit window lasts CYC cycles, with sclk_o low for the first RISE cycles and high for the remaining ones.
- R4: Transmitted bits go out LSB first. Each bit is on dat_o from the start of its window, RISE cycles before the sclk_o rise, until the window ends CYC-RISE cycles after that rise.
- R5: ti (control bit 1, also ti_o) sets at the 96th clock edge after the edge of the data write.
- R6: Reception starts one cycle after the port is idle with mode 00, rx_en 1 and ri 0. dat_i is sampled at every sclk_o rise, LSB first.
- R7: At the 96th edge after reception starts, ri (control bit 0, also ri_o) sets and the received byte appears at address 1 in the same edge.
- R8: ti and ri stay set until software writes 0 to them. Hardware never clears them.
- R9: With mode other than 00, neither a data write nor rx_en starts a transfer, and sclk_o stays high.
- R10: A data write during a transfer is ignored. The byte in flight and the ti timing are unchanged.
- R11: dat_o keeps the last transmitted bit while idle and during reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 data |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for the selected address |
| dat_i | input | 1 | Serial receive data |
| dat_o | output | 1 | Serial transmit data |
| sclk_o | output | 1 | Shift clock, idles high |
| ti_o | output | 1 | Transmit-done flag |
| ri_o | output | 1 | Receive-done flag |

## Verification
Each table byte is sent and then received. The set 0xA5, 0x00, 0xFF, 0x3C and 0x81 tells apart bit-order reversal, stuck data lines, a shifted bit window and a wrong end bit. The flag edges are checked on exact cycles, so an off-by-one in the phase or bit counters is caught. Separate directed runs cover:
- a non-zero mode field,
- a data write in the middle of a transfer,
- control bits that only hold storage.

These runs separate gating faults from shifting faults.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic [1:0] mode;
    logic       multi;
    logic       rx_en;
    logic       tx9;
    logic       rx9;
    logic       ti;
    logic       ri;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } st_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int CYC  = 12,
  parameter int RISE = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_tx,
  input  logic start_rx,
  output st_e  state,
  output logic sclk,
  output logic pre_rise,
  output logic bit_end,
  output logic done
);
  localparam int PW = $clog2(CYC);
  localparam int BW = $clog2(DW);

  st_e           st_q, st_d;
  logic [PW-1:0] phase_q, phase_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          en;

  always_comb begin
    pre_rise = (st_q != ST_IDLE) && (phase_q == PW'(RISE - 1));
    bit_end  = (st_q != ST_IDLE) && (phase_q == PW'(CYC - 1));
    done     = bit_end && (bit_q == BW'(DW - 1));
    sclk     = (st_q == ST_IDLE) || (phase_q >= PW'(RISE));
    en       = (st_q != ST_IDLE) || start_tx || start_rx;
  end

  always_comb begin
    st_d    = st_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    if (st_q == ST_IDLE) begin
      phase_d = '0;
      bit_d   = '0;
      if (start_tx)      st_d = ST_TX;
      else if (start_rx) st_d = ST_RX;
    end else if (bit_end) begin
      phase_d = '0;
      if (done) st_d  = ST_IDLE;
      else      bit_d = bit_q + 1'b1;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (en) begin
      st_q    <= st_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift
  import ssp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          shift_out,
  input  logic          sample,
  input  logic          dat_i,
  output logic          dat_o,
  output logic [DW-1:0] sreg
);
  logic [DW-1:0] sreg_q, sreg_d;
  logic          dout_q, dout_d;
  logic          en;

  always_comb begin
    sreg_d = sreg_q;
    dout_d = dout_q;
    en     = load || shift_out || sample;
    if (load) begin
      dout_d = load_data[0];
      sreg_d = load_data >> 1;
    end else if (shift_out) begin
      dout_d = sreg_q[0];
      sreg_d = sreg_q >> 1;
    end else if (sample) begin
      sreg_d = {dat_i, sreg_q[DW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      dout_q <= 1'b1;
    end else if (en) begin
      sreg_q <= sreg_d;
      dout_q <= dout_d;
    end
  end

  assign dat_o = dout_q;
  assign sreg  = sreg_q;
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          set_ti,
  input  logic          set_ri,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_data,
  output ctrl_t         ctrl,
  output logic [DW-1:0] rdata
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] rbuf_q;
  logic          ctrl_en;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = (wr_en && addr == ADDR_CTRL) || set_ti || set_ri;
    if (wr_en && addr == ADDR_CTRL) ctrl_d = ctrl_t'(wdata);
    if (set_ti) ctrl_d.ti = 1'b1;
    if (set_ri) ctrl_d.ri = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rbuf_q <= '0;
    else if (rx_load) rbuf_q <= rx_data;
  end

  assign ctrl  = ctrl_q;
  assign rdata = (addr == ADDR_CTRL) ? DW'(ctrl_q) : rbuf_q;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int CYC  = 12,
  parameter int RISE = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       dat_i,
  output logic       dat_o,
  output logic       sclk_o,
  output logic       ti_o,
  output logic       ri_o
);
  ctrl_t         ctrl;
  st_e           state;
  logic          pre_rise, bit_end, done;
  logic          idle, is_tx, is_rx, busy;
  logic          start_tx, start_rx, shift_out, sample;
  logic          set_ti, set_ri;
  logic [DW-1:0] sreg;
  logic [1:0]    cur_mode;

  always_comb begin
    idle      = (state == ST_IDLE);
    is_tx     = (state == ST_TX);
    is_rx     = (state == ST_RX);
    busy      = !idle;
    cur_mode  = ctrl.mode;
    start_tx  = idle && (ctrl.mode == 2'b00) && wr_en && (addr == ADDR_DATA);
    start_rx  = idle && (ctrl.mode == 2'b00) && !(wr_en && addr == ADDR_DATA)
                && ctrl.rx_en && !ctrl.ri;
    shift_out = is_tx && bit_end && !done;
    sample    = is_rx && pre_rise;
    set_ti    = is_tx && done;
    set_ri    = is_rx && done;
  end

  ssp_seq #(.CYC(CYC), .RISE(RISE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
    .state(state), .sclk(sclk_o), .pre_rise(pre_rise), .bit_end(bit_end),
    .done(done)
  );

  ssp_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_tx), .load_data(wdata),
    .shift_out(shift_out), .sample(sample), .dat_i(dat_i),
    .dat_o(dat_o), .sreg(sreg)
  );

  ssp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .set_ti(set_ti), .set_ri(set_ri), .rx_load(set_ri), .rx_data(sreg),
    .ctrl(ctrl), .rdata(rdata)
  );

  assign ti_o = ctrl.ti;
  assign ri_o = ctrl.ri;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int RISE = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       sclk_o,
  input logic       dat_o,
  input logic       ti_o,
  input logic       ri_o,
  input logic       busy,
  input logic [1:0] mode
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (sclk_o) low_cnt <= '0;
    else             low_cnt <= low_cnt + 1'b1;
  end

  // R3: shift clock never stays low beyond RISE cycles, and idles high
  assert_low_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= 8'(RISE));
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);

  // R4: data output moves only when the shift clock falls
  assert_data_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dat_o) |-> $fell(sclk_o));

  // R5 / R7: flags rise only at the end of a transfer or by a software write
  assert_ti_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_o) |-> ((!busy && $past(busy)) || $past(wr_en && addr == 1'b0 && wdata[1])));
  assert_ri_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_o) |-> ((!busy && $past(busy)) || $past(wr_en && addr == 1'b0 && wdata[0])));

  // R8: flags fall only by software write of zero
  assert_ti_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ti_o) |-> $past(wr_en && addr == 1'b0 && !wdata[1]));
  assert_ri_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ri_o) |-> $past(wr_en && addr == 1'b0 && !wdata[0]));

  // R9: a transfer only begins under mode 00
  assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(mode) == 2'b00));
endmodule

bind sync_shift_port ssp_checker #(.RISE(RISE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sclk_o(sclk_o), .dat_o(dat_o), .ti_o(ti_o), .ri_o(ri_o),
  .busy(busy), .mode(cur_mode)
);

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       dat_i = 1'b1;
  logic [7:0] rdata;
  logic       dat_o, sclk_o, ti_o, ri_o;

  int checks = 0;
  int fails  = 0;

  // {byte, bit 7 of byte = expected idle level of dat_o afterwards}
  localparam logic [8:0] VEC [5] = '{
    {8'hA5, 1'b1}, {8'h00, 1'b0}, {8'hFF, 1'b1}, {8'h3C, 1'b0}, {8'h81, 1'b1}
  };

  sync_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dat_i(dat_i), .dat_o(dat_o), .sclk_o(sclk_o),
    .ti_o(ti_o), .ri_o(ri_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic send_byte(input logic [7:0] b);
    reg_wr(1'b1, b);
    chk("R3 sclk low at start", {31'd0, sclk_o}, 32'd0);
    chk("R4 bit0 at window start", {31'd0, dat_o}, {31'd0, b[0]});
    for (int c = 1; c <= 96; c++) begin
      @(posedge clk);
      #1;
      if (c < 96 && (c % 12) == 10) begin
        chk("R4 bit at rise", {31'd0, dat_o}, {31'd0, b[c/12]});
        chk("R3 sclk high after RISE", {31'd0, sclk_o}, 32'd1);
      end
      if (c < 96 && (c % 12) == 9)
        chk("R3 sclk low before rise", {31'd0, sclk_o}, 32'd0);
      if (c == 95) chk("R5 ti not yet", {31'd0, ti_o}, 32'd0);
      if (c == 96) chk("R5 ti at edge 96", {31'd0, ti_o}, 32'd1);
    end
  endtask

  task automatic recv_byte(input logic [7:0] b, input logic hold_bit);
    logic [7:0] rd;
    reg_wr(1'b0, 8'h10);
    for (int k = 0; k < 8; k++) begin
      while (sclk_o !== 1'b0) @(negedge clk);
      dat_i = b[k];
      chk("R11 dat_o held during receive", {31'd0, dat_o}, {31'd0, hold_bit});
      while (sclk_o !== 1'b1) @(negedge clk);
    end
    @(posedge clk); #1;
    chk("R7 ri not yet", {31'd0, ri_o}, 32'd0);
    @(posedge clk); #1;
    chk("R7 ri at edge 96", {31'd0, ri_o}, 32'd1);
    reg_rd(1'b1, rd);
    chk("R6 R7 received byte", {24'd0, rd}, {24'd0, b});
    reg_wr(1'b0, 8'h00);
    chk("R8 ri cleared by software", {31'd0, ri_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sclk", {31'd0, sclk_o}, 32'd1);
    chk("R1 dat_o", {31'd0, dat_o}, 32'd1);
    chk("R1 ti", {31'd0, ti_o}, 32'd0);
    chk("R1 ri", {31'd0, ri_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    reg_rd(1'b0, rd);
    chk("R1 ctrl", {24'd0, rd}, 32'h00);
    reg_rd(1'b1, rd);
    chk("R1 rx buffer", {24'd0, rd}, 32'h00);

    // Vector walk: transmit then receive each pattern
    foreach (VEC[i]) begin
      send_byte(VEC[i][8:1]);
      repeat (40) @(posedge clk);
      #1;
      chk("R8 ti sticky", {31'd0, ti_o}, 32'd1);
      chk("R11 dat_o holds last bit", {31'd0, dat_o}, {31'd0, VEC[i][0]});
      reg_wr(1'b0, 8'h00);
      chk("R8 ti cleared by software", {31'd0, ti_o}, 32'd0);
      recv_byte(VEC[i][8:1], VEC[i][0]);
    end

    // R2: storage bits read back, no transfer started
    reg_wr(1'b0, 8'h2C);
    reg_rd(1'b0, rd);
    chk("R2 ctrl readback", {24'd0, rd}, 32'h2C);
    repeat (5) @(posedge clk); #1;
    chk("R2 no transfer from storage bits", {31'd0, sclk_o}, 32'd1);
    reg_wr(1'b0, 8'h00);

    // R9: non-zero mode blocks transmit and receive
    reg_wr(1'b0, 8'h40);
    reg_wr(1'b1, 8'h55);
    for (int n = 0; n < 100; n++) begin
      @(posedge clk); #1;
      if (sclk_o !== 1'b1) begin
        chk("R9 sclk stays high", {31'd0, sclk_o}, 32'd1);
        break;
      end
    end
    chk("R9 no ti", {31'd0, ti_o}, 32'd0);
    reg_wr(1'b0, 8'h50);
    repeat (30) @(posedge clk); #1;
    chk("R9 no receive", {31'd0, sclk_o}, 32'd1);
    reg_rd(1'b0, rd);
    chk("R9 ctrl readback", {24'd0, rd}, 32'h50);
    reg_wr(1'b0, 8'h00);

    // R10: data write during a transfer is ignored
    reg_wr(1'b1, 8'hA5);
    repeat (29) @(posedge clk);
    reg_wr(1'b1, 8'h00);
    repeat (64) @(posedge clk);
    #1;
    chk("R10 last bit of original byte", {31'd0, dat_o}, 32'd1);
    chk("R10 sclk high at rise", {31'd0, sclk_o}, 32'd1);
    @(posedge clk); #1;
    chk("R10 ti not yet", {31'd0, ti_o}, 32'd0);
    @(posedge clk); #1;
    chk("R10 ti on original timing", {31'd0, ti_o}, 32'd1);
    reg_wr(1'b0, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule